// File: doc/BRIEF.md
# Three-Wire Control Register Slave

This block is a synchronous slave for a three-wire serial control bus of the SPI/Microwire kind. A host lowers the active-low select, clocks in a 24-bit frame and then raises the select. The frame carries a 20-bit data word first and then a 4-bit register address. The word is written into the addressed register only when the select is released, and only if exactly 24 bits arrived.

All three bus lines are brought into a fast system clock through two-flop synchronisers. Data is taken on each detected rising edge of the bus clock. The block holds a small bank of 20-bit control registers. One of them is the configuration register, which comes out of reset with a defined non-zero value. Its fields are decoded onto dedicated outputs, including a charge-pump current in microamps and a gated lock indicator. Every register has a write strobe that pulses for one system clock when it loads.

Top module: `tw_ctrl_regs`

## Requirements
- R1: After reset the configuration register (address 3) holds 0x0D03F and registers 0 to 2 hold zero. The decoded outputs then show PLL enabled, IQ level high, divide-by-2 off, VCO bypass off, current code 00 (200 µA), positive polarity, and lock-detect mode 1. No strobe is active.
- R2: A frame is shifted in MSB first while select is low. The first 20 bits are the data, MSB first. The last 4 bits are the address, MSB first, so the final bit is address bit 0. Addresses 0 to 3 select registers 0 to 3.
- R3: A register changes only when select is released after a complete frame. While select stays low after the 24th bit, every register holds its old value.
- R4: If select rises after any bit count other than 24 (fewer or more), the frame is discarded and no register or strobe changes.
- R5: A complete frame addressed to 4 through 15 changes no register and raises no strobe.
- R6: Each accepted write raises exactly one strobe, the one for the addressed register, for exactly one system clock, in the same cycle the register takes the new value.
- R7: The configuration fields decode as follows: bit 15 is PLL enable, bit 12 is IQ level high, bit 11 is divide-by-2, bit 10 is VCO bypass, bits 9:8 are the current code, bit 5 is phase-detector polarity, and bit 0 is lock-detect mode.
- R8: The current output maps code 00, 01, 10 and 11 to 200, 260, 400 and 530 µA.
- R9: The lock output follows the lock input when lock-detect mode is 1. It is held at 0 when the mode is 0 (test mode). It responds to a new mode value in the cycle the configuration register loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tw_cs_ni | input | 1 | Bus select, active low, asynchronous |
| tw_sclk_i | input | 1 | Bus clock, asynchronous |
| tw_sdi_i | input | 1 | Bus serial data, asynchronous |
| pll_lock_i | input | 1 | Raw PLL lock indication |
| reg_q_o | output | NUM_REGS*20 | All register contents, register n at bits [20n+19:20n] |
| reg_wr_stb_o | output | NUM_REGS | One-cycle load strobe per register |
| if_pll_en_o | output | 1 | PLL enable (config bit 15) |
| iq_level_hi_o | output | 1 | IQ input level select, 1 = high level (bit 12) |
| lo_div2_o | output | 1 | LO output divide-by-2 enable (bit 11) |
| vco_bypass_o | output | 1 | VCO bypass (bit 10) |
| cp_code_o | output | 2 | Charge-pump current code (bits 9:8) |
| cp_ua_o | output | 10 | Charge-pump current in µA |
| pd_pol_pos_o | output | 1 | Phase-detector polarity, 1 = positive (bit 5) |
| lock_detect_o | output | 1 | Lock indication, gated by lock-detect mode (bit 0) |

## Verification
A configuration write and a change on the lock input can land in the same system cycle. The lock output must then use the new mode at once, with no stale gating. The bench provokes this case. It writes a configuration word that clears the lock-detect mode, and it raises the lock input exactly in the system cycle in which the synchronised select release commits the frame. It judges the result by sampling the lock output one half-cycle after that edge, where it must read 0. A later write that sets the mode again must let the lock through.

// File: rtl/tw_pkg.sv
package tw_pkg;

  localparam int DATA_W   = 20;
  localparam int ADDR_W   = 4;
  localparam int FRAME_W  = DATA_W + ADDR_W;
  localparam int CP_UA_W  = 10;

  localparam logic [DATA_W-1:0] CFG_RESET = 20'h0D03F;

  // Configuration word layout, MSB first; reserved fields keep bit positions.
  typedef struct packed {
    logic [3:0] rsv_19_16;
    logic       pll_en;      // 15
    logic [1:0] rsv_14_13;
    logic       iq_hi;       // 12
    logic       lo_div2;     // 11
    logic       vco_bypass;  // 10
    logic [1:0] cp_code;     // 9:8
    logic [1:0] rsv_7_6;
    logic       pd_pol;      // 5
    logic [3:0] rsv_4_1;
    logic       ld_mode;     // 0
  } cfg_word_t;

  function automatic logic [CP_UA_W-1:0] cp_code_to_ua(input logic [1:0] code);
    logic [CP_UA_W-1:0] ua;
    unique case (code)
      2'b00:   ua = CP_UA_W'(200);
      2'b01:   ua = CP_UA_W'(260);
      2'b10:   ua = CP_UA_W'(400);
      default: ua = CP_UA_W'(530);
    endcase
    return ua;
  endfunction

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int          N_BITS    = 3,
  parameter int          STAGES    = 2,
  parameter logic [N_BITS-1:0] RESET_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_BITS-1:0] async_i,
  output logic [N_BITS-1:0] sync_o
);

  localparam int CHAIN_W = STAGES * N_BITS;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
    else         chain_q <= {chain_q[CHAIN_W-N_BITS-1:0], async_i};
  end

  assign sync_o = chain_q[CHAIN_W-1 -: N_BITS];

  initial begin
    if (STAGES < 2) $error("tw_sync needs at least two stages");
  end

endmodule

// File: rtl/tw_shifter.sv
module tw_shifter
  import tw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_s_i,
  input  logic              sclk_s_i,
  input  logic              sdi_s_i,
  output logic              commit_o,
  output logic [DATA_W-1:0] data_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int              CNT_W    = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic               sclk_d_q;
  logic               cs_d_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] shift_q;

  // Named events for the checks
  logic sclk_rise;
  logic cs_release;
  logic bit_take;

  assign sclk_rise  = sclk_s_i & ~sclk_d_q;
  assign cs_release = cs_n_s_i & ~cs_d_q;
  assign bit_take   = ~cs_n_s_i & sclk_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      cs_d_q   <= 1'b1;
      cnt_q    <= '0;
      shift_q  <= '0;
    end else begin
      sclk_d_q <= sclk_s_i;
      cs_d_q   <= cs_n_s_i;
      if (cs_n_s_i)                          cnt_q <= '0;
      else if (bit_take && cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
      if (bit_take) shift_q <= {shift_q[FRAME_W-2:0], sdi_s_i};
    end
  end

  assign commit_o = cs_release && (cnt_q == CNT_FULL);
  assign data_o   = shift_q[FRAME_W-1:ADDR_W];
  assign addr_o   = shift_q[ADDR_W-1:0];

  AST_CNT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_OVER);  // R4

  AST_CNT_CLEARS_AFTER_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> (cnt_q == '0));  // R4

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_s_i && cnt_q != '0) |-> (cnt_q - $past(cnt_q)) <= 1);  // R2

endmodule

// File: rtl/tw_regbank.sv
module tw_regbank
  import tw_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int CFG_ADDR = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       commit_i,
  input  logic [DATA_W-1:0]          data_i,
  input  logic [ADDR_W-1:0]          addr_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic [NUM_REGS-1:0]        stb_o
);

  localparam logic [ADDR_W:0] REGS_LIM = (ADDR_W+1)'(NUM_REGS);

  logic [DATA_W-1:0]   regs_q [NUM_REGS];
  logic [NUM_REGS-1:0] stb_q;
  logic                addr_valid;
  logic                write_dropped;

  assign addr_valid    = {1'b0, addr_i} < REGS_LIM;
  assign write_dropped = commit_i & ~addr_valid;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL = (g == CFG_ADDR) ? CFG_RESET : '0;
    logic hit;
    assign hit = commit_i && (addr_i == ADDR_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= RST_VAL;
        stb_q[g]  <= 1'b0;
      end else begin
        stb_q[g] <= hit;
        if (hit) regs_q[g] <= data_i;
      end
    end

    assign regs_o[g*DATA_W +: DATA_W] = regs_q[g];

    AST_STB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_q[g] |=> !stb_q[g]);  // R6

    AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(regs_q[g]) |-> stb_q[g]);  // R3
  end

  assign stb_o = stb_q;

  AST_STB_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb_q));  // R6

  AST_DROP_NO_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_dropped |=> (stb_q == '0));  // R5

endmodule

// File: rtl/tw_ctrl_regs.sv
module tw_ctrl_regs
  import tw_pkg::*;
#(
  parameter int NUM_REGS    = 4,
  parameter int CFG_ADDR    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tw_cs_ni,
  input  logic                       tw_sclk_i,
  input  logic                       tw_sdi_i,
  input  logic                       pll_lock_i,
  output logic [NUM_REGS*DATA_W-1:0] reg_q_o,
  output logic [NUM_REGS-1:0]        reg_wr_stb_o,
  output logic                       if_pll_en_o,
  output logic                       iq_level_hi_o,
  output logic                       lo_div2_o,
  output logic                       vco_bypass_o,
  output logic [1:0]                 cp_code_o,
  output logic [CP_UA_W-1:0]         cp_ua_o,
  output logic                       pd_pol_pos_o,
  output logic                       lock_detect_o
);

  logic [2:0]        bus_s;
  logic              commit;
  logic [DATA_W-1:0] frame_data;
  logic [ADDR_W-1:0] frame_addr;
  cfg_word_t         cfg;
  logic              unused_cfg_rsv;

  tw_sync #(
    .N_BITS    (3),
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (3'b100)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({tw_cs_ni, tw_sclk_i, tw_sdi_i}),
    .sync_o  (bus_s)
  );

  tw_shifter u_shifter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_n_s_i (bus_s[2]),
    .sclk_s_i (bus_s[1]),
    .sdi_s_i  (bus_s[0]),
    .commit_o (commit),
    .data_o   (frame_data),
    .addr_o   (frame_addr)
  );

  tw_regbank #(
    .NUM_REGS (NUM_REGS),
    .CFG_ADDR (CFG_ADDR)
  ) u_regbank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .data_i   (frame_data),
    .addr_i   (frame_addr),
    .regs_o   (reg_q_o),
    .stb_o    (reg_wr_stb_o)
  );

  assign cfg = cfg_word_t'(reg_q_o[CFG_ADDR*DATA_W +: DATA_W]);
  assign unused_cfg_rsv = ^{cfg.rsv_19_16, cfg.rsv_14_13, cfg.rsv_7_6, cfg.rsv_4_1};

  assign if_pll_en_o   = cfg.pll_en;
  assign iq_level_hi_o = cfg.iq_hi;
  assign lo_div2_o     = cfg.lo_div2;
  assign vco_bypass_o  = cfg.vco_bypass;
  assign cp_code_o     = cfg.cp_code;
  assign cp_ua_o       = cp_code_to_ua(cfg.cp_code);
  assign pd_pol_pos_o  = cfg.pd_pol;
  assign lock_detect_o = cfg.ld_mode & pll_lock_i;

  AST_CP_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_ua_o inside {10'd200, 10'd260, 10'd400, 10'd530});  // R8

  AST_LOCK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_q_o[CFG_ADDR*DATA_W] |-> !lock_detect_o);  // R9

  AST_CFG_ONLY_ON_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cp_code_o) |-> reg_wr_stb_o[CFG_ADDR]);  // R3

endmodule

// File: tb/tw_ctrl_regs_bench.sv
module tw_ctrl_regs_bench;

  localparam int NR   = 4;
  localparam int CFG  = 3;
  localparam int DW   = 20;
  localparam int NVEC = 12;

  // entry = {address[3:0], data[19:0], bit count[5:0]}
  localparam logic [29:0] VEC [NVEC] = '{
    {4'h3, 20'h00000, 6'd24},
    {4'h0, 20'hA5A5A, 6'd24},
    {4'h3, 20'h01B21, 6'd24},
    {4'h1, 20'hFFFFF, 6'd23},
    {4'h2, 20'h12345, 6'd25},
    {4'h7, 20'h55555, 6'd24},
    {4'h3, 20'h08201, 6'd24},
    {4'h1, 20'h3C3C3, 6'd24},
    {4'hF, 20'hFFFFF, 6'd24},
    {4'h3, 20'h0D13F, 6'd24},
    {4'h2, 20'h13579, 6'd24},
    {4'h3, 20'h0F4DE, 6'd22}
  };
  localparam int UA [4] = '{200, 260, 400, 530};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, lock = 1'b0;
  logic [NR*DW-1:0] reg_q;
  logic [NR-1:0]    stb;
  logic pll_en, iq_hi, div2, vbyp, pd_pol, lock_o;
  logic [1:0] cp_code;
  logic [9:0] cp_ua;

  tw_ctrl_regs u_tw_ctrl_regs (
    .clk_i (clk), .rst_ni (rst_n),
    .tw_cs_ni (cs_n), .tw_sclk_i (sclk), .tw_sdi_i (sdi),
    .pll_lock_i (lock),
    .reg_q_o (reg_q), .reg_wr_stb_o (stb),
    .if_pll_en_o (pll_en), .iq_level_hi_o (iq_hi), .lo_div2_o (div2),
    .vco_bypass_o (vbyp), .cp_code_o (cp_code), .cp_ua_o (cp_ua),
    .pd_pol_pos_o (pd_pol), .lock_detect_o (lock_o)
  );

  int checks = 0;
  int fails  = 0;
  int stb_cnt [NR];
  logic [DW-1:0] model [NR];

  always @(negedge clk) begin
    for (int i = 0; i < NR; i++) if (stb[i] === 1'b1) stb_cnt[i]++;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_stb();
    for (int i = 0; i < NR; i++) stb_cnt[i] = 0;
  endtask

  task automatic bus_frame(input logic [23:0] word, input int nbits, input bit release_cs);
    cs_n = 1'b0;
    #60;
    for (int b = 0; b < nbits; b++) begin
      sdi = (b < 24) ? word[23-b] : 1'b0;
      #30 sclk = 1'b1;
      #60 sclk = 1'b0;
      #30;
    end
    sdi = 1'b0;
    if (release_cs) begin
      #30 cs_n = 1'b1;
      #100;
    end
  endtask

  task automatic check_regs(input string tag);
    for (int r = 0; r < NR; r++) chk(reg_q[r*DW +: DW], model[r], tag);
  endtask

  task automatic check_cfg(input string tag);
    logic [DW-1:0] m;
    m = model[CFG];
    chk(pll_en, m[15], {tag, " R7 pll_en"});
    chk(iq_hi,  m[12], {tag, " R7 iq_hi"});
    chk(div2,   m[11], {tag, " R7 div2"});
    chk(vbyp,   m[10], {tag, " R7 vco_bypass"});
    chk(cp_code, m[9:8], {tag, " R7 cp_code"});
    chk(cp_ua,  UA[m[9:8]], {tag, " R8 cp_ua"});
    chk(pd_pol, m[5], {tag, " R7 pd_pol"});
    chk(lock_o, m[0] & lock, {tag, " R9 lock"});
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    model[CFG] = 20'h0D03F;
    clear_stb();
    #40 rst_n = 1'b1;
    #60;

    // R1: reset state
    check_regs("R1 reset");
    check_cfg("R1");
    for (int r = 0; r < NR; r++) chk(stb_cnt[r], 0, "R1 strobe");

    // Vector table
    lock = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      logic [3:0]    a;
      logic [DW-1:0] d;
      int            nb;
      bit            wr;
      string         tag;
      a  = VEC[v][29:26];
      d  = VEC[v][25:6];
      nb = int'(VEC[v][5:0]);
      wr = (nb == 24) && (a < NR);
      tag = (nb != 24) ? "R4" : ((a >= NR) ? "R5" : "R2");
      clear_stb();
      bus_frame({d, a}, nb, 1'b1);
      for (int r = 0; r < NR; r++) begin
        bit hit;
        hit = wr && (a == r);
        if (hit) model[r] = d;
        chk(stb_cnt[r], hit ? 1 : 0, "R6 strobe");
      end
      check_regs(tag);
      check_cfg(tag);
    end

    // R3: nothing changes before select release
    clear_stb();
    bus_frame({20'h00001, 4'h3}, 24, 1'b0);
    #200;
    check_regs("R3 held");
    chk(stb_cnt[CFG], 0, "R3 no strobe yet");
    cs_n = 1'b1;
    #100;
    model[CFG] = 20'h00001;
    check_regs("R3 released");
    chk(stb_cnt[CFG], 1, "R6 strobe after release");

    // R9: mode cleared in the same cycle the lock input rises
    lock = 1'b0;
    #20;
    bus_frame({20'h08000, 4'h3}, 24, 1'b0);
    cs_n = 1'b1;
    #20 lock = 1'b1;
    #10;
    model[CFG] = 20'h08000;
    chk(lock_o, 1'b0, "R9 same-cycle gating");
    chk(pll_en, 1'b1, "R7 pll_en same cycle");
    #50;
    check_cfg("R9 after");

    // R9: mode set again lets lock through
    bus_frame({20'h00001, 4'h3}, 24, 1'b1);
    model[CFG] = 20'h00001;
    chk(lock_o, 1'b1, "R9 lock passes");
    lock = 1'b0;
    #20;
    chk(lock_o, 1'b0, "R9 lock follows input");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule